// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Key-Protected Registers

This block supervises software with a counter that advances on every enabled time step. The time step is either every core clock cycle or every cycle on which a slow external tick strobe is high. Once running, the counter first works through a warning span chosen from a 17-entry table. When that span ends, a warning flag is set, and it can drive an interrupt line. The counter then works through a final span chosen from an 8-entry table. If the final span also ends, the block emits a one-cycle reset request, but only when reset requests are allowed. The total time from a fresh start to the reset request is therefore the warning span plus the final span.

Software reaches the block through a small word-addressed register bus, with a combinational read path. A kick write restarts the warning span. The configuration word and the kick register are both guarded. A key write arms a single protected access, and the next protected write always uses up that arming, whether it succeeds or not. The warning and final flags are sticky and are cleared by writing ones to them. A synthesis parameter divides every span by a power of two, which gives short spans for scaled-down builds.

Top module: `guard_timer`

## Requirements
- R1: After reset, the configuration, arm and flag registers read as zero, and `irq_o` and `rst_req_o` are low.
- R2: Writing 0x5AA5 to the key register (address 2) arms exactly one protected write. The arm state reads back at bit 0 of address 2, and a second protected write that is not preceded by its own key write is ignored.
- R3: A write to the configuration register (address 0) or the kick register (address 1) is ignored when the block is not armed.
- R4: Any protected write clears the arm state, even a kick write whose value is not the kick key.
- R5: An armed write of 0xCAFE to address 1 returns the counter to the start of the warning span. An armed kick write with any other value leaves the counter running undisturbed.
- R6: The warning flag (bit 0 of address 3) is set exactly L step edges after the counter starts. L = 2^(e − S), where S is the scale parameter and e is 6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 22, 23, 25, 27, 29 or 31 for warning codes 0 to 16.
- R7: After the warning span, the final span runs for 2^(7 + c − S) steps, where c is the final code. At its end the final flag (bit 1 of address 3) is set and the counter returns to the warning span. `rst_req_o` pulses high for one cycle on the following cycle, and only if reset is allowed.
- R8: `irq_o` is high exactly while the warning flag is set and the interrupt-allow bit is set.
- R9: Writing to address 3 clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R10: When the source bit is 0, the counter advances only on cycles where `ext_tick` is high.
- R11: While the run bit is 0, the counter stays cleared, so a later enable starts a full warning span.
- R12: Configuration layout: bit 0 run, bit 1 source (1 = core clock), bit 2 interrupt allow, bit 3 reset allow, bits 6:4 final code, bits 12:8 warning code. A warning code above 16 is stored and read back as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 config, 1 kick, 2 key, 3 flags |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| ext_tick | input | 1 | Slow tick strobe, used when the source bit is 0 |
| irq_o | output | 1 | Warning interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with TIME_SHIFT = 4, a 32-bit counter and 32-bit data. With these values, warning codes 0 and 1 give spans of 4 and 16 steps, and final code 0 gives 8 steps. Every stage boundary, kick reload, disable-and-restart sequence and slow-tick count therefore completes within a few dozen cycles and can be checked against an exact cycle number. The saturation of large warning codes is checked through configuration read-back, because the longest spans are out of reach even at this scale.

// File: rtl/guard_timer_pkg.sv
`timescale 1ns/1ps
package guard_timer_pkg;

    localparam int REG_ADDR_W   = 2;
    localparam int WARN_CODE_W  = 5;
    localparam int FINAL_CODE_W = 3;
    localparam int WARN_CODE_TOP = 16;

    localparam logic [15:0] ARM_KEY  = 16'h5AA5;
    localparam logic [15:0] KICK_KEY = 16'hCAFE;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CFG   = 2'd0,
        REG_KICK  = 2'd1,
        REG_KEY   = 2'd2,
        REG_FLAGS = 2'd3
    } reg_sel_e;

    typedef enum logic {
        STG_WARN  = 1'b0,
        STG_FINAL = 1'b1
    } stage_e;

    typedef struct packed {
        logic [WARN_CODE_W-1:0]  warn_code;
        logic [FINAL_CODE_W-1:0] final_code;
        logic                    rst_allow;
        logic                    irq_allow;
        logic                    src_core;
        logic                    run;
    } cfg_t;

    typedef struct packed {
        logic final_hit;
        logic warn_hit;
    } flags_t;

    // Exponent of two for each warning code; codes past the top saturate.
    function automatic int warn_log2(input logic [WARN_CODE_W-1:0] code);
        case (code)
            5'd0:    return 6;
            5'd1:    return 8;
            5'd2:    return 10;
            5'd3:    return 11;
            5'd4:    return 12;
            5'd5:    return 13;
            5'd6:    return 14;
            5'd7:    return 15;
            5'd8:    return 17;
            5'd9:    return 19;
            5'd10:   return 21;
            5'd11:   return 22;
            5'd12:   return 23;
            5'd13:   return 25;
            5'd14:   return 27;
            5'd15:   return 29;
            default: return 31;
        endcase
    endfunction

    function automatic int final_log2(input logic [FINAL_CODE_W-1:0] code);
        return 7 + int'(code);
    endfunction

    function automatic logic [WARN_CODE_W-1:0] sat_warn(input logic [WARN_CODE_W-1:0] code);
        return (code > WARN_CODE_W'(WARN_CODE_TOP)) ? WARN_CODE_W'(WARN_CODE_TOP) : code;
    endfunction

endpackage

// File: rtl/guard_span.sv
`timescale 1ns/1ps
module guard_span
    import guard_timer_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int TIME_SHIFT = 0
) (
    input  logic [WARN_CODE_W-1:0]  warn_code,
    input  logic [FINAL_CODE_W-1:0] final_code,
    output logic [CNT_W-1:0]        warn_len,
    output logic [CNT_W-1:0]        final_len
);

    generate
        if (TIME_SHIFT == 0) begin : g_full
            always_comb begin
                warn_len  = CNT_W'(1) << warn_log2(warn_code);
                final_len = CNT_W'(1) << final_log2(final_code);
            end
        end else begin : g_scaled
            int warn_e;
            int final_e;
            always_comb begin
                warn_e  = warn_log2(warn_code) - TIME_SHIFT;
                final_e = final_log2(final_code) - TIME_SHIFT;
                if (warn_e < 0)  warn_e  = 0;
                if (final_e < 0) final_e = 0;
                warn_len  = CNT_W'(1) << warn_e;
                final_len = CNT_W'(1) << final_e;
            end
        end
    endgenerate

endmodule

// File: rtl/guard_count.sv
`timescale 1ns/1ps
module guard_count
    import guard_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             src_core,
    input  logic             rst_allow,
    input  logic             ext_tick,
    input  logic             kick,
    input  logic [CNT_W-1:0] warn_len,
    input  logic [CNT_W-1:0] final_len,
    output logic             warn_hit,
    output logic             final_hit,
    output logic             rst_req
);

    stage_e           stage_q;
    logic [CNT_W-1:0] count_q;
    logic             step;
    logic             at_end;
    logic [CNT_W-1:0] span_last;

    always_comb begin
        step      = run && (src_core || ext_tick);
        span_last = (stage_q == STG_WARN) ? (warn_len - CNT_W'(1)) : (final_len - CNT_W'(1));
        at_end    = (count_q >= span_last);
        warn_hit  = step && !kick && at_end && (stage_q == STG_WARN);
        final_hit = step && !kick && at_end && (stage_q == STG_FINAL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= STG_WARN;
            count_q <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= final_hit && rst_allow;
            if (!run || kick) begin
                stage_q <= STG_WARN;
                count_q <= '0;
            end else if (step) begin
                if (at_end) begin
                    count_q <= '0;
                    stage_q <= (stage_q == STG_WARN) ? STG_FINAL : STG_WARN;
                end else begin
                    count_q <= count_q + CNT_W'(1);
                end
            end
        end
    end

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst) !run |=> (count_q == '0)); // R11
    AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (rst) kick |=> (count_q == '0 && stage_q == STG_WARN)); // R5
    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst) rst_req |=> !rst_req); // R7
    AST_RST_RESTARTS: assert property (@(posedge clk) disable iff (rst) rst_req |-> (count_q == '0 && stage_q == STG_WARN)); // R7
    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (rst) (run && !src_core && !ext_tick && !kick) |=> $stable(count_q)); // R10

endmodule

// File: rtl/guard_regs.sv
`timescale 1ns/1ps
module guard_regs
    import guard_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  warn_hit,
    input  logic                  final_hit,
    output logic [DATA_W-1:0]     rdata,
    output cfg_t                  cfg,
    output flags_t                flags,
    output logic                  kick
);

    logic armed_q;
    logic prot_wr;
    logic key_wr;
    logic cfg_wr;
    logic [1:0] clr;
    cfg_t cfg_next;

    always_comb begin
        key_wr  = wr && (addr == REG_KEY);
        cfg_wr  = wr && (addr == REG_CFG);
        prot_wr = cfg_wr || (wr && (addr == REG_KICK));
        kick    = wr && (addr == REG_KICK) && armed_q && (wdata == DATA_W'(KICK_KEY));
        clr     = (wr && (addr == REG_FLAGS)) ? wdata[1:0] : 2'b00;

        cfg_next.run        = wdata[0];
        cfg_next.src_core   = wdata[1];
        cfg_next.irq_allow  = wdata[2];
        cfg_next.rst_allow  = wdata[3];
        cfg_next.final_code = wdata[6:4];
        cfg_next.warn_code  = sat_warn(wdata[12:8]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cfg     <= '0;
            flags   <= '0;
        end else begin
            if (key_wr)
                armed_q <= (wdata == DATA_W'(ARM_KEY));
            else if (prot_wr)
                armed_q <= 1'b0;
            if (cfg_wr && armed_q)
                cfg <= cfg_next;
            flags <= (flags & ~flags_t'(clr)) | flags_t'({final_hit, warn_hit});
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            REG_CFG: begin
                rdata[0]    = cfg.run;
                rdata[1]    = cfg.src_core;
                rdata[2]    = cfg.irq_allow;
                rdata[3]    = cfg.rst_allow;
                rdata[6:4]  = cfg.final_code;
                rdata[12:8] = cfg.warn_code;
            end
            REG_KEY:   rdata[0]   = armed_q;
            REG_FLAGS: rdata[1:0] = flags;
            default:   rdata      = '0;
        endcase
    end

    AST_ARM_SPENT: assert property (@(posedge clk) disable iff (rst) (armed_q && prot_wr) |=> !armed_q); // R4
    AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (rst) (!armed_q && cfg_wr) |=> $stable(cfg)); // R3
    AST_WARN_SOURCE: assert property (@(posedge clk) disable iff (rst) $rose(flags.warn_hit) |-> $past(warn_hit)); // R6
    AST_CODE_SAT: assert property (@(posedge clk) disable iff (rst) cfg.warn_code <= WARN_CODE_W'(WARN_CODE_TOP)); // R12

endmodule

// File: rtl/guard_timer.sv
`timescale 1ns/1ps
module guard_timer
    import guard_timer_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 32,
    parameter int TIME_SHIFT = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  ext_tick,
    output logic                  irq_o,
    output logic                  rst_req_o
);

    cfg_t             cfg;
    flags_t           flags;
    logic             kick;
    logic             warn_hit;
    logic             final_hit;
    logic [CNT_W-1:0] warn_len;
    logic [CNT_W-1:0] final_len;

    guard_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .warn_hit  (warn_hit),
        .final_hit (final_hit),
        .rdata     (bus_rdata),
        .cfg       (cfg),
        .flags     (flags),
        .kick      (kick)
    );

    guard_span #(.CNT_W(CNT_W), .TIME_SHIFT(TIME_SHIFT)) u_span (
        .warn_code  (cfg.warn_code),
        .final_code (cfg.final_code),
        .warn_len   (warn_len),
        .final_len  (final_len)
    );

    guard_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .run       (cfg.run),
        .src_core  (cfg.src_core),
        .rst_allow (cfg.rst_allow),
        .ext_tick  (ext_tick),
        .kick      (kick),
        .warn_len  (warn_len),
        .final_len (final_len),
        .warn_hit  (warn_hit),
        .final_hit (final_hit),
        .rst_req   (rst_req_o)
    );

    assign irq_o = flags.warn_hit && cfg.irq_allow;

endmodule

// File: tb/guard_timer_tb.sv
`timescale 1ns/1ps
module guard_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic        irq_o;
    logic        rst_req_o;

    guard_timer #(.DATA_W(32), .CNT_W(32), .TIME_SHIFT(4)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_tick  (ext_tick),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    localparam int EV_IRQ = 1;
    localparam int EV_RST = 2;
    typedef struct { int kind; int at; string req; } ev_t;
    ev_t exp_q[$];

    int n_chk = 0;
    int n_err = 0;
    int last_edge = 0;
    bit done = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(int kind, int at, string req);
        ev_t e;
        e.kind = kind; e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic see(int kind);
        ev_t e;
        n_chk++;
        if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL R7/R8 unexpected event actual=kind %0d at %0d expected=none", kind, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.at != cyc) begin
                n_err++;
                $display("FAIL %s actual=kind %0d at %0d expected=kind %0d at %0d", e.req, kind, cyc, e.kind, e.at);
            end
        end
    endtask

    logic prev_irq = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (irq_o && !prev_irq) see(EV_IRQ);
            if (rst_req_o) see(EV_RST);
        end
        prev_irq <= irq_o;
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        last_edge = cyc;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic set_cfg(logic [31:0] v);
        wr(2'd2, 32'h5AA5);
        wr(2'd0, v);
    endtask

    task automatic tick();
        ext_tick = 1'b1;
        @(negedge clk);
        ext_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(bit run, bit core, bit ia, bit ra, int fc, int wc);
        return 32'(run) | (32'(core) << 1) | (32'(ia) << 2) | (32'(ra) << 3)
             | (32'(fc & 7) << 4) | (32'(wc & 31) << 8);
    endfunction

    task automatic stop_and_clear();
        set_cfg(32'd0);
        wr(2'd3, 32'd3);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        end
    endtask

    initial begin
        logic [31:0] d;
        int c0;
        int k;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); check("R1 cfg", d, 0);
        rd(2'd2, d); check("R1 arm", d, 0);
        rd(2'd3, d); check("R1 flags", d, 0);
        check("R1 irq", irq_o, 0);
        check("R1 rst_req", rst_req_o, 0);

        // R3 locked config write
        wr(2'd0, mk(1, 1, 1, 1, 0, 0));
        rd(2'd0, d); check("R3 locked cfg", d, 0);

        // R2 arm visible, R6/R7 basic two-stage run
        wr(2'd2, 32'h5AA5);
        rd(2'd2, d); check("R2 armed", d, 1);
        wr(2'd0, mk(1, 1, 1, 1, 0, 0));
        c0 = last_edge;
        push(EV_IRQ, c0 + 4, "R6 warn span");
        push(EV_RST, c0 + 12, "R7 final span");
        rd(2'd2, d); check("R4 arm spent", d, 0);
        wait_cyc(c0 + 12);
        set_cfg(32'd0);
        rd(2'd3, d); check("R7 both flags", d, 3);
        wr(2'd3, 32'd1);
        rd(2'd3, d); check("R9 clear warn only", d, 2);
        check("R9 irq low", irq_o, 0);
        wr(2'd3, 32'd2);
        rd(2'd3, d); check("R9 clear final", d, 0);

        // R8 / R7: no allows, flags set, no outputs
        set_cfg(mk(1, 1, 0, 0, 0, 0));
        c0 = last_edge;
        wait_cyc(c0 + 14);
        check("R8 irq masked", irq_o, 0);
        rd(2'd3, d); check("R8 flags set", d, 3);
        stop_and_clear();
        rd(2'd3, d); check("R9 cleared", d, 0);

        // R4 / R5 kick handling
        set_cfg(mk(1, 1, 1, 1, 0, 1));
        c0 = last_edge;
        wr(2'd2, 32'h5AA5);
        wr(2'd1, 32'h1234);
        rd(2'd2, d); check("R4 bad kick spends arm", d, 0);
        wr(2'd1, 32'hCAFE);
        wr(2'd2, 32'h5AA5);
        wr(2'd1, 32'hCAFE);
        k = last_edge;
        push(EV_IRQ, k + 16, "R5 kick reload");
        push(EV_RST, k + 24, "R5 kick final");
        wait_cyc(k + 24);
        stop_and_clear();

        // R2 single use of one arm
        set_cfg(mk(0, 1, 0, 0, 2, 3));
        wr(2'd0, mk(0, 1, 0, 0, 5, 9));
        rd(2'd0, d); check("R2 one write per arm", d, mk(0, 1, 0, 0, 2, 3));

        // R11 disable clears counter
        set_cfg(mk(1, 1, 1, 1, 0, 1));
        c0 = last_edge;
        wait_cyc(c0 + 10);
        set_cfg(32'd0);
        wait_cyc(c0 + 24);
        check("R11 idle irq", irq_o, 0);
        rd(2'd3, d); check("R11 idle flags", d, 0);
        set_cfg(mk(1, 1, 1, 1, 0, 1));
        c0 = last_edge;
        push(EV_IRQ, c0 + 16, "R11 full span after re-enable");
        push(EV_RST, c0 + 24, "R11 final after re-enable");
        wait_cyc(c0 + 24);
        stop_and_clear();

        // R10 slow tick source
        set_cfg(mk(1, 0, 1, 0, 0, 0));
        c0 = last_edge;
        wait_cyc(c0 + 40);
        check("R10 no ticks irq", irq_o, 0);
        rd(2'd3, d); check("R10 no ticks flags", d, 0);
        for (int i = 0; i < 3; i++) tick();
        check("R10 three ticks", irq_o, 0);
        push(EV_IRQ, cyc + 1, "R10 fourth tick");
        tick();
        rd(2'd3, d); check("R10 warn flag", d, 1);
        stop_and_clear();

        // R12 layout and saturation
        set_cfg(mk(0, 0, 1, 1, 5, 31));
        rd(2'd0, d); check("R12 code 31 saturates", d, mk(0, 0, 1, 1, 5, 16));
        set_cfg(mk(0, 1, 0, 1, 7, 17));
        rd(2'd0, d); check("R12 code 17 saturates", d, mk(0, 1, 0, 1, 7, 16));
        set_cfg(mk(0, 1, 1, 0, 3, 16));
        rd(2'd0, d); check("R12 code 16 kept", d, mk(0, 1, 1, 0, 3, 16));
        set_cfg(mk(0, 0, 0, 0, 1, 9));
        rd(2'd0, d); check("R12 code 9 kept", d, mk(0, 0, 0, 0, 1, 9));

        repeat (20) @(negedge clk);
        check("R6/R7 all expected events seen", exp_q.size(), 0);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

endmodule